// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is a trace sink. While capture is on, each valid 32-bit trace word from the input port goes into an on-chip RAM at the write pointer. The pointer then advances and wraps at the end of the RAM. A sticky wrap flag tells software where the oldest word is. If the flag is clear, the oldest word is at address zero. If it is set, the oldest word is at the current write pointer. Software reads the buffer back through a read-data register, and each read of that register advances the read pointer. Software can load either pointer directly. While capture is off, software can also write words into the RAM.

Capture can end in three ways. Software can clear the enable bit. A stop-on-trigger option can end it a programmed number of words after a trigger. A stop-on-flush option can end it when a flush completes. A flush starts from an input pin or from a self-clearing control bit. When capture is off, a flush completes in the cycle after the request. When capture is on, the flush waits for a cycle with no incoming word. A status bit reports that capture has come to a halt.

Top module: `trace_ring_sink`

## Requirements
- R1: After reset the following hold. Capture is off: control offset 0x020 bit 0 reads 0. Both pointers read 0. The wrap flag (offset 0x00C bit 0) reads 0. The halted flag (offset 0x300 bit 1) reads 1. Offset 0x004 reads the DEPTH parameter.
- R2: With capture on, each cycle with trc_valid high stores trc_data at the write pointer (offset 0x018) and advances the pointer by one. With capture off, trace words are ignored and the write pointer holds.
- R3: When the write pointer wraps from DEPTH-1 to 0, the wrap flag sets and stays set. Only a software write of 0 to the write pointer clears it. Writing a nonzero value to the pointer leaves the flag unchanged.
- R4: A read of offset 0x010 with bus_rd high returns the RAM word at the read pointer (offset 0x014). The read pointer then advances by one, modulo DEPTH.
- R5: With capture off, a write to offset 0x024 stores the written word at the write pointer and advances the pointer. With capture on, that write is ignored.
- R6: When stop-on-trigger (offset 0x304 bit 13) is set, the first trigger seen during capture arms a countdown loaded from offset 0x01C. The word in the trigger cycle is stored. Exactly that many further words are then stored, and capture enable clears. With a count of 0, no word after the trigger is stored.
- R7: The halted flag (offset 0x300 bit 1) reads 1 whenever capture is off. Writing 1 to capture enable clears the flag.
- R8: A flush request sets offset 0x304 bit 6. The request can come from flush_req or from writing 1 to that bit. With capture off, the bit reads 1 for exactly one cycle and then clears.
- R9: With capture on, a pending flush completes only in a cycle where trc_valid is low. If stop-on-flush (offset 0x304 bit 12) is set, completion also clears capture enable.
- R10: Software writes to offsets 0x014 and 0x018 load the read and write pointers directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Read strobe; advances the read pointer at offset 0x010 |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Combinational register read data |
| trc_valid | input | 1 | Trace word valid |
| trc_data | input | 32 | Trace word |
| trc_trig | input | 1 | Trigger pulse |
| flush_req | input | 1 | Flush request |

## Verification
Two functions meet in the same cycles here: a flush completing and a trace word being stored. The bench raises flush_req in the middle of a continuous burst of valid words while capture is on and stop-on-flush is set. It checks two things. First, the flush bit stays set and capture stays on for as long as words keep arriving. Second, the flush completes, capture clears and the halted flag sets only after the first idle cycle. A final write-pointer count confirms that every word in the burst was stored and none was lost to the stop. A second conflict is also covered: the trigger countdown reaching zero in the same cycle as a valid word. The stored-word count confirms that this word is refused.

// File: rtl/trace_ring_sink.sv
module trace_ring_sink #(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        trc_valid,
  input  logic [31:0] trc_data,
  input  logic        trc_trig,
  input  logic        flush_req
);
  localparam int AW = $clog2(DEPTH);

  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [31:0]   trg_cnt, left;
  logic          cap_en, full, armed, fmt_stopped;
  logic          fmt_en, stop_flush, stop_trig, flush_pend;

  wire a_wptr = bus_addr == 12'h018;
  wire a_rptr = bus_addr == 12'h014;
  wire a_rdat = bus_addr == 12'h010;
  wire a_wdat = bus_addr == 12'h024;
  wire a_ctl  = bus_addr == 12'h020;
  wire a_trg  = bus_addr == 12'h01C;
  wire a_fctl = bus_addr == 12'h304;

  wire halt    = armed && (left == 32'd0);
  wire store   = cap_en && trc_valid && !halt;
  wire sw_push = bus_wr && a_wdat && !cap_en;
  wire adv     = store || sw_push;
  wire wrap    = adv && (wptr == AW'(DEPTH - 1));
  wire fl_done = flush_pend && (!cap_en || !trc_valid);
  wire fl_new  = flush_req || (bus_wr && a_fctl && bus_wdata[6]);

  always_ff @(posedge clk) begin
    if (store)        mem[wptr] <= trc_data;
    else if (sw_push) mem[wptr] <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr        <= '0;
      rptr        <= '0;
      trg_cnt     <= '0;
      left        <= '0;
      cap_en      <= 1'b0;
      full        <= 1'b0;
      armed       <= 1'b0;
      fmt_stopped <= 1'b1;
      fmt_en      <= 1'b0;
      stop_flush  <= 1'b0;
      stop_trig   <= 1'b0;
      flush_pend  <= 1'b0;
    end else begin
      if (adv)  wptr <= wptr + 1'b1;
      if (wrap) full <= 1'b1;
      if (bus_wr && a_wptr) begin
        wptr <= bus_wdata[AW-1:0];
        if (bus_wdata == 32'd0) full <= 1'b0;
      end

      if (bus_rd && a_rdat) rptr <= rptr + 1'b1;
      if (bus_wr && a_rptr) rptr <= bus_wdata[AW-1:0];

      if (bus_wr && a_trg) trg_cnt <= bus_wdata;
      if (bus_wr && a_fctl) begin
        fmt_en     <= bus_wdata[0];
        stop_flush <= bus_wdata[12];
        stop_trig  <= bus_wdata[13];
      end

      if (store && armed) left <= left - 32'd1;
      if (cap_en && stop_trig && trc_trig && !armed) begin
        armed <= 1'b1;
        left  <= trg_cnt;
      end

      flush_pend <= (flush_pend && !fl_done) || fl_new;

      if (bus_wr && a_ctl) begin
        cap_en      <= bus_wdata[0];
        fmt_stopped <= !bus_wdata[0];
        armed       <= 1'b0;
      end
      if (cap_en && halt) begin
        cap_en      <= 1'b0;
        armed       <= 1'b0;
        fmt_stopped <= 1'b1;
      end
      if (fl_done && stop_flush) begin
        cap_en      <= 1'b0;
        fmt_stopped <= 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = 32'd0;
    case (bus_addr)
      12'h004: bus_rdata = 32'(DEPTH);
      12'h00C: bus_rdata = {31'd0, full};
      12'h010: bus_rdata = mem[rptr];
      12'h014: bus_rdata = 32'(rptr);
      12'h018: bus_rdata = 32'(wptr);
      12'h01C: bus_rdata = trg_cnt;
      12'h020: bus_rdata = {31'd0, cap_en};
      12'h300: bus_rdata = {30'd0, fmt_stopped, 1'b0};
      12'h304: bus_rdata = {18'd0, stop_trig, stop_flush, 5'd0, flush_pend, 5'd0, fmt_en};
      default: bus_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/trace_ring_sink_chk.sv
module trace_ring_sink_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [11:0]   bus_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [31:0]   bus_wdata,
  input logic          flush_req,
  input logic          cap_en,
  input logic          full,
  input logic          armed,
  input logic [31:0]   left,
  input logic          flush_pend,
  input logic          fmt_stopped,
  input logic [AW-1:0] wptr,
  input logic [AW-1:0] rptr
);
  wire wptr_wr = bus_wr && (bus_addr == 12'h018);
  wire rptr_wr = bus_wr && (bus_addr == 12'h014);
  wire ctl_wr  = bus_wr && (bus_addr == 12'h020);
  wire push_wr = bus_wr && (bus_addr == 12'h024);
  wire fl_set  = flush_req || (bus_wr && (bus_addr == 12'h304) && bus_wdata[6]);

  a_r3_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    full && !wptr_wr |=> full);

  a_r2_idle_wptr: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en && !wptr_wr && !push_wr |=> $stable(wptr));

  a_r4_rptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && (bus_addr == 12'h010) && !rptr_wr |=> rptr == AW'($past(rptr) + 1'b1));

  a_r6_count_stop: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en && armed && (left == 32'd0) && !ctl_wr |=> !cap_en);

  a_r7_halted_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |-> fmt_stopped);

  a_r8_flush_quick: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pend && !cap_en && !fl_set |=> !flush_pend);
endmodule

bind trace_ring_sink trace_ring_sink_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .flush_req(flush_req),
  .cap_en(cap_en), .full(full), .armed(armed), .left(left),
  .flush_pend(flush_pend), .fmt_stopped(fmt_stopped),
  .wptr(wptr), .rptr(rptr)
);

// File: tb/sim_trace_ring_sink.sv
module sim_trace_ring_sink;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        trc_valid = 1'b0, trc_trig = 1'b0, flush_req = 1'b0;
  logic [31:0] trc_data = '0;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  trace_ring_sink #(.DEPTH(DEPTH)) u0 (.*);

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic peek(logic [11:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic pop(output logic [31:0] d);
    @(negedge clk);
    bus_addr = 12'h010; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic burst(int n, logic [31:0] base, int trig_at);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      trc_valid = 1'b1; trc_data = base + i; trc_trig = (i == trig_at);
    end
    @(negedge clk);
    trc_valid = 1'b0; trc_trig = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    peek(12'h020, v); check("R1 ctl", v, 0);
    peek(12'h018, v); check("R1 wptr", v, 0);
    peek(12'h014, v); check("R1 rptr", v, 0);
    peek(12'h00C, v); check("R1 full", v, 0);
    peek(12'h300, v); check("R1 halted", v, 2);
    peek(12'h004, v); check("R1 depth", v, DEPTH);
  endtask

  task automatic t_capture;
    logic [31:0] v;
    wr(12'h020, 1);
    peek(12'h300, v); check("R7 halted clear", v, 0);
    burst(3, 32'hA0, -1);
    peek(12'h018, v); check("R2 wptr after 3", v, 3);
    wr(12'h020, 0);
    peek(12'h300, v); check("R7 halted set", v, 2);
    burst(2, 32'hEE, -1);
    peek(12'h018, v); check("R2 ignored when off", v, 3);
    wr(12'h014, 0);
    for (int i = 0; i < 3; i++) begin
      pop(v); check("R4 readback", v, 32'hA0 + i);
    end
    peek(12'h014, v); check("R4 rptr advanced", v, 3);
  endtask

  task automatic t_swwrite;
    logic [31:0] v;
    wr(12'h018, DEPTH - 2);
    peek(12'h018, v); check("R10 wptr load", v, DEPTH - 2);
    wr(12'h024, 32'h1111);
    wr(12'h024, 32'h2222);
    peek(12'h018, v); check("R5 wptr wrapped", v, 0);
    peek(12'h00C, v); check("R3 full set", v, 1);
    wr(12'h014, DEPTH - 1);
    pop(v); check("R5 sw word", v, 32'h2222);
    peek(12'h014, v); check("R4 rptr wrap", v, 0);
    wr(12'h020, 1);
    wr(12'h024, 32'h3333);
    peek(12'h018, v); check("R5 ignored when on", v, 0);
    wr(12'h020, 0);
    wr(12'h018, 5);
    peek(12'h00C, v); check("R3 kept on nonzero", v, 1);
    wr(12'h018, 0);
    peek(12'h00C, v); check("R3 cleared", v, 0);
  endtask

  task automatic t_trigger;
    logic [31:0] v;
    wr(12'h01C, 4);
    wr(12'h304, 32'h2001);
    wr(12'h020, 1);
    burst(10, 32'h100, 2);
    peek(12'h018, v); check("R6 stored 2+1+4", v, 7);
    peek(12'h020, v); check("R6 capture off", v, 0);
    peek(12'h300, v); check("R7 halted after trig", v, 2);
    wr(12'h018, 0);
    wr(12'h01C, 0);
    wr(12'h020, 1);
    burst(4, 32'h200, 1);
    peek(12'h018, v); check("R6 zero count", v, 2);
    peek(12'h020, v); check("R6 zero count off", v, 0);
  endtask

  task automatic t_flush_idle;
    logic [31:0] v;
    wr(12'h304, 32'h0040);
    peek(12'h304, v); check("R8 bit set", v[6], 1);
    @(negedge clk);
    peek(12'h304, v); check("R8 bit cleared", v[6], 0);
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
    peek(12'h304, v); check("R8 pin set", v[6], 1);
    @(negedge clk);
    peek(12'h304, v); check("R8 pin cleared", v[6], 0);
  endtask

  task automatic t_flush_busy;
    logic [31:0] v;
    wr(12'h018, 0);
    wr(12'h304, 32'h1001);
    wr(12'h020, 1);
    @(negedge clk); trc_valid = 1'b1; trc_data = 32'h300;
    @(negedge clk); trc_data = 32'h301; flush_req = 1'b1;
    @(negedge clk); trc_data = 32'h302; flush_req = 1'b0;
    peek(12'h304, v); check("R9 pending while busy", v[6], 1);
    @(negedge clk); trc_data = 32'h303;
    peek(12'h020, v); check("R9 capture still on", v, 1);
    @(negedge clk); trc_valid = 1'b0;
    @(negedge clk);
    peek(12'h020, v); check("R9 capture stopped", v, 0);
    peek(12'h304, v); check("R9 flush done", v[6], 0);
    peek(12'h300, v); check("R7 halted after flush", v, 2);
    peek(12'h018, v); check("R9 no word lost", v, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_capture;
    t_swwrite;
    t_trigger;
    t_flush_idle;
    t_flush_busy;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule